// File: doc/BRIEF.md
# Multi-channel ADC threshold monitor

This block watches up to eight ADC channels and flags any reading that leaves a per-channel window of codes. Each channel slot holds its own interval, threshold pair and enable bits, and runs its own interval timer. When a slot's timer expires, the slot becomes due. The next reading that arrives for that channel is then stored and compared against the slot's thresholds. A reading below the low threshold sets that channel's bit in the low-side status byte. A reading above the high threshold sets its bit in the high-side status byte. The interrupt output is raised while any status bit is set.

Software sees a byte-wide register port. It does not write the slots directly. It fills one shared staging window (target slot, interval, thresholds, programmable interval, enables), sets a handshake flag and writes a conversion request. While the global enable is set, the block copies the window into the chosen slot on that request and drops the handshake flag. Each status byte has two views: one that reads the status and ignores writes, and one that clears bits written as 1. The latest accepted reading of every channel can be read back.

Top module: `adc_thr_mon`

## Requirements
- R1: After reset, both status bytes, the handshake flag, every result register and every staging register read 0, and irq_o is 0.
- R2: Writing 1 to bit 0 of the handshake register (0x04) sets the flag. A write to the request register (0x19) with bit 7 set is accepted only if both the enable bit (bit 7 of 0x18) and the flag are 1. An accepted request copies the staging window into the slot named by bits 7:5 of the control register (0x10), and the flag reads 0 from the next cycle.
- R3: A request made while the enable bit is clear, or while the flag is clear, is ignored. The flag keeps its value and no slot changes.
- R4: Bits 3:2 of the control register pick the slot interval: 0 for 50 ms, 1 for 100 ms, 2 for 1000 ms, and 3 for the programmable count of ms in 0x16 (low byte) and 0x17 (high byte). A value of 0 counts as 1 ms. One ms is TICK_CYC clocks. A slot first becomes due between (N-1) and N ms after its commit, where N is the interval.
- R5: A reading (adc_valid_i with adc_ch_i naming the channel) is taken only when its slot is due and has measurement enable (bit 7 of 0x11) set. Taking it stores the code, which reads back at 0x20+2*ch (low byte) and 0x21+2*ch (high byte), and restarts the wait for the next due. Readings at any other time are ignored.
- R6: A taken reading strictly below the slot's low threshold (0x12 low byte, 0x13 high byte) sets bit ch of the low status byte (0x00), but only if bit 0 of 0x11 was set at commit.
- R7: A taken reading strictly above the slot's high threshold (0x14 low byte, 0x15 high byte) sets bit ch of the high status byte (0x02), but only if bit 1 of 0x11 was set at commit.
- R8: Status bits stay set until software writes 1 to the same bit of the clear view: 0x01 for low, 0x03 for high. This holds even when later readings fall inside the limits. Writes to 0x00 and 0x02 have no effect.
- R9: irq_o is 1 exactly when at least one bit of either status byte is set.
- R10: A slot committed with measurement enable 0 stops its timer. It takes no readings and sets no status bits.
- R11: Each slot keeps its own thresholds and enables. A commit to one slot leaves the other slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i (combinational) |
| adc_valid_i | input | 1 | ADC reading strobe |
| adc_ch_i | input | CH_W | Channel the reading belongs to |
| adc_data_i | input | 16 | ADC reading code |
| irq_o | output | 1 | Threshold interrupt |

## Verification
Every slot is swept with readings one below, exactly at, and above each threshold, plus one reading in the middle. Across the slots, all four combinations of the two interrupt enables are used. This separates the strict compares from inclusive ones and shows that each enable gates only its own side. For every interval code, one reading arrives just before the earliest due time and one just after the latest. This tells a correct timer apart from one that is early, late or decoded to the wrong interval. Requests are also tried with the enable bit clear, with the handshake flag clear, and with measurement enable off, and each of these must leave the channel visibly unchanged at the ports.

// File: rtl/adcmon_pkg.sv
package adcmon_pkg;
  localparam int unsigned CODE_W = 16;

  localparam logic [7:0] A_STAT_LO = 8'h00;
  localparam logic [7:0] A_CLR_LO  = 8'h01;
  localparam logic [7:0] A_STAT_HI = 8'h02;
  localparam logic [7:0] A_CLR_HI  = 8'h03;
  localparam logic [7:0] A_HS      = 8'h04;
  localparam logic [7:0] A_CTL     = 8'h10;
  localparam logic [7:0] A_MEAS    = 8'h11;
  localparam logic [7:0] A_TLO_L   = 8'h12;
  localparam logic [7:0] A_TLO_H   = 8'h13;
  localparam logic [7:0] A_THI_L   = 8'h14;
  localparam logic [7:0] A_THI_H   = 8'h15;
  localparam logic [7:0] A_INT_L   = 8'h16;
  localparam logic [7:0] A_INT_H   = 8'h17;
  localparam logic [7:0] A_EN      = 8'h18;
  localparam logic [7:0] A_REQ     = 8'h19;
  localparam logic [7:0] A_DATA    = 8'h20;

  localparam logic [15:0] IVL0_MS = 16'd50;
  localparam logic [15:0] IVL1_MS = 16'd100;
  localparam logic [15:0] IVL2_MS = 16'd1000;

  typedef struct packed {
    logic              meas_en;
    logic              hi_en;
    logic              lo_en;
    logic [1:0]        isel;
    logic [CODE_W-1:0] thr_lo;
    logic [CODE_W-1:0] thr_hi;
    logic [15:0]       prog_ms;
  } slot_cfg_t;
endpackage

// File: rtl/adcmon_tick.sv
module adcmon_tick #(
  parameter int unsigned TICK_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adcmon_slot.sv
module adcmon_slot
  import adcmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_tick_i,
  input  logic              commit_i,
  input  slot_cfg_t         cfg_i,
  input  logic              smp_i,
  input  logic [CODE_W-1:0] smp_data_i,
  output logic [CODE_W-1:0] result_o,
  output logic              lo_hit_o,
  output logic              hi_hit_o
);
  slot_cfg_t   cfg_q;
  logic [15:0] ms_cnt_q;
  logic [15:0] lim;
  logic        due_q;
  logic        take;

  always_comb begin
    unique case (cfg_q.isel)
      2'd0:    lim = IVL0_MS;
      2'd1:    lim = IVL1_MS;
      2'd2:    lim = IVL2_MS;
      default: lim = (cfg_q.prog_ms == 16'd0) ? 16'd1 : cfg_q.prog_ms;
    endcase
  end

  assign take     = smp_i & due_q & cfg_q.meas_en;
  assign lo_hit_o = take & cfg_q.lo_en & (smp_data_i < cfg_q.thr_lo);
  assign hi_hit_o = take & cfg_q.hi_en & (smp_data_i > cfg_q.thr_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      ms_cnt_q <= '0;
      due_q    <= 1'b0;
    end else if (commit_i) begin
      cfg_q    <= cfg_i;
      ms_cnt_q <= '0;
      due_q    <= 1'b0;
    end else begin
      if (cfg_q.meas_en && ms_tick_i) begin
        if (ms_cnt_q >= lim - 16'd1) begin
          due_q    <= 1'b1;
          ms_cnt_q <= '0;
        end else begin
          ms_cnt_q <= ms_cnt_q + 16'd1;
        end
      end
      if (take) due_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   result_o <= '0;
    else if (take) result_o <= smp_data_i;
  end
endmodule

// File: rtl/adc_thr_mon.sv
module adc_thr_mon
  import adcmon_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned TICK_CYC = 50000,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              adc_valid_i,
  input  logic [CH_W-1:0]   adc_ch_i,
  input  logic [CODE_W-1:0] adc_data_i,
  output logic              irq_o
);
  localparam logic [7:0] DATA_END = A_DATA + 8'(2 * NUM_CH);

  logic [7:0]  ctl_q, meas_q, en_q;
  logic [15:0] tlo_q, thi_q, int_q;
  logic        hs_q;
  logic [NUM_CH-1:0] stat_lo_q, stat_hi_q, hit_lo, hit_hi, clr_lo, clr_hi, commit;
  logic [CODE_W-1:0] res [NUM_CH];
  logic        ms_tick, req, acc;
  slot_cfg_t   win_cfg;
  logic [7:0]  doff;
  logic [CH_W-1:0] ridx;

  assign req = we_i && (addr_i == A_REQ) && wdata_i[7];
  assign acc = req && en_q[7] && hs_q;

  assign win_cfg = '{meas_en: meas_q[7], hi_en: meas_q[1], lo_en: meas_q[0],
                     isel: ctl_q[3:2], thr_lo: tlo_q, thr_hi: thi_q, prog_ms: int_q};

  adcmon_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(ms_tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    assign commit[i] = acc && (ctl_q[7:5] == 3'(i));
    adcmon_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ms_tick_i (ms_tick),
      .commit_i  (commit[i]),
      .cfg_i     (win_cfg),
      .smp_i     (adc_valid_i && (adc_ch_i == CH_W'(i))),
      .smp_data_i(adc_data_i),
      .result_o  (res[i]),
      .lo_hit_o  (hit_lo[i]),
      .hi_hit_o  (hit_hi[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0; meas_q <= '0; en_q <= '0;
      tlo_q <= '0; thi_q  <= '0; int_q <= '0;
      hs_q  <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          A_CTL:   ctl_q        <= wdata_i;
          A_MEAS:  meas_q       <= wdata_i;
          A_TLO_L: tlo_q[7:0]   <= wdata_i;
          A_TLO_H: tlo_q[15:8]  <= wdata_i;
          A_THI_L: thi_q[7:0]   <= wdata_i;
          A_THI_H: thi_q[15:8]  <= wdata_i;
          A_INT_L: int_q[7:0]   <= wdata_i;
          A_INT_H: int_q[15:8]  <= wdata_i;
          A_EN:    en_q         <= wdata_i;
          default: ;
        endcase
      end
      if (acc)                          hs_q <= 1'b0;
      else if (we_i && addr_i == A_HS)  hs_q <= wdata_i[0];
    end
  end

  // set wins over a clear in the same cycle
  assign clr_lo = (we_i && addr_i == A_CLR_LO) ? wdata_i[NUM_CH-1:0] : '0;
  assign clr_hi = (we_i && addr_i == A_CLR_HI) ? wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_lo_q <= '0;
      stat_hi_q <= '0;
    end else begin
      stat_lo_q <= (stat_lo_q & ~clr_lo) | hit_lo;
      stat_hi_q <= (stat_hi_q & ~clr_hi) | hit_hi;
    end
  end

  assign irq_o = (|stat_lo_q) | (|stat_hi_q);

  assign doff = addr_i - A_DATA;
  assign ridx = doff[CH_W:1];

  always_comb begin
    rdata_o = '0;
    if (addr_i >= A_DATA && addr_i < DATA_END) begin
      rdata_o = addr_i[0] ? res[ridx][15:8] : res[ridx][7:0];
    end else begin
      unique case (addr_i)
        A_STAT_LO, A_CLR_LO: rdata_o = 8'(stat_lo_q);
        A_STAT_HI, A_CLR_HI: rdata_o = 8'(stat_hi_q);
        A_HS:    rdata_o = {7'd0, hs_q};
        A_CTL:   rdata_o = ctl_q;
        A_MEAS:  rdata_o = meas_q;
        A_TLO_L: rdata_o = tlo_q[7:0];
        A_TLO_H: rdata_o = tlo_q[15:8];
        A_THI_L: rdata_o = thi_q[7:0];
        A_THI_H: rdata_o = thi_q[15:8];
        A_INT_L: rdata_o = int_q[7:0];
        A_INT_H: rdata_o = int_q[15:8];
        A_EN:    rdata_o = en_q;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/adcmon_chk.sv
module adcmon_chk
  import adcmon_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [7:0]        addr_i,
  input logic [7:0]        wdata_i,
  input logic              irq_o,
  input logic              hs_i,
  input logic              en_i,
  input logic [NUM_CH-1:0] stat_lo_i,
  input logic [NUM_CH-1:0] stat_hi_i,
  input logic [NUM_CH-1:0] hit_lo_i,
  input logic [NUM_CH-1:0] hit_hi_i
);
  logic wr_req, wr_clr_lo, wr_clr_hi;
  assign wr_req    = we_i && (addr_i == A_REQ) && wdata_i[7];
  assign wr_clr_lo = we_i && (addr_i == A_CLR_LO);
  assign wr_clr_hi = we_i && (addr_i == A_CLR_HI);

  AST_HS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && en_i && hs_i) |=> !hs_i); // R2
  AST_REQ_OFF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && !en_i) |=> $stable(hs_i)); // R3
  AST_LO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_clr_lo |=> ((stat_lo_i & $past(stat_lo_i)) == $past(stat_lo_i))); // R8
  AST_HI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_clr_hi |=> ((stat_hi_i & $past(stat_hi_i)) == $past(stat_hi_i))); // R8
  AST_LO_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_lo && hit_lo_i == '0) |=> ((stat_lo_i & $past(wdata_i[NUM_CH-1:0])) == '0)); // R8
  AST_IRQ_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|hit_lo_i) || (|hit_hi_i)) |=> irq_o); // R9
endmodule

bind adc_thr_mon adcmon_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .hs_i     (hs_q),
  .en_i     (en_q[7]),
  .stat_lo_i(stat_lo_q),
  .stat_hi_i(stat_hi_q),
  .hit_lo_i (hit_lo),
  .hit_hi_i (hit_hi)
);

// File: tb/adc_thr_mon_tb.sv
module adc_thr_mon_tb;
  localparam int NCH = 8;
  localparam int T   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic we = 1'b0;
  logic [7:0] rdata;
  logic adc_valid = 1'b0;
  logic [2:0] adc_ch = '0;
  logic [15:0] adc_data = '0;
  logic irq;

  integer n_tests = 0, n_fail = 0;
  logic done = 1'b0;
  logic [15:0] exp_data [NCH];

  always #10 clk = ~clk;

  adc_thr_mon #(.NUM_CH(NCH), .TICK_CYC(T)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .adc_valid_i(adc_valid), .adc_ch_i(adc_ch),
    .adc_data_i(adc_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd16(input int ch, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(8'h20 + 8'(2 * ch), lo);
    rd(8'h21 + 8'(2 * ch), hi);
    d = {hi, lo};
  endtask

  task automatic feed(input int ch, input logic [15:0] d);
    adc_ch = 3'(ch); adc_data = d; adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stage(input int ch, input logic [1:0] isel, input logic [7:0] meas,
                       input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] pms);
    wr(8'h10, {3'(ch), 1'b0, isel, 2'b00});
    wr(8'h11, meas);
    wr(8'h12, lo[7:0]); wr(8'h13, lo[15:8]);
    wr(8'h14, hi[7:0]); wr(8'h15, hi[15:8]);
    wr(8'h16, pms[7:0]); wr(8'h17, pms[15:8]);
  endtask

  task automatic commit_req();
    wr(8'h18, 8'h80);
    wr(8'h04, 8'h01);
    wr(8'h19, 8'h80);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] w;
    for (int i = 0; i < NCH; i++) exp_data[i] = '0;
    wait_cyc(3);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, b); chk("R1 stat_lo", b, 8'h00);
    rd(8'h02, b); chk("R1 stat_hi", b, 8'h00);
    rd(8'h04, b); chk("R1 handshake", b, 8'h00);
    rd(8'h12, b); chk("R1 window", b, 8'h00);
    for (int i = 0; i < NCH; i++) begin
      rd16(i, w); chk("R1 result", w, 16'h0000);
    end
    chk("R1 irq", irq, 1'b0);

    // R4 interval codes: early reading ignored, late reading taken
    for (int k = 0; k < 4; k++) begin
      int lim;
      lim = (k == 0) ? 50 : (k == 1) ? 100 : (k == 2) ? 1000 : 5;
      stage(0, 2'(k), 8'h80, 16'h0000, 16'hFFFF, 16'd5);
      commit_req();
      wait_cyc((lim - 1) * T - 1);
      feed(0, 16'h1000 + 16'(k));
      rd16(0, w); chk("R4 early reading ignored", w, exp_data[0]);
      wait_cyc(T);
      feed(0, 16'h2000 + 16'(k));
      exp_data[0] = 16'h2000 + 16'(k);
      rd16(0, w); chk("R4 reading taken after interval", w, exp_data[0]);
    end

    // R2 handshake flag drops after an accepted request
    stage(1, 2'd3, 8'h80, 16'h0000, 16'hFFFF, 16'd1);
    wr(8'h18, 8'h80);
    wr(8'h04, 8'h01);
    rd(8'h04, b); chk("R2 flag set by software", b, 8'h01);
    wr(8'h19, 8'h80);
    rd(8'h04, b); chk("R2 flag cleared by block", b, 8'h00);

    // R5 R6 R7 R11 sweep: all slots, all enable combinations, edge codes
    for (int i = 0; i < NCH; i++) begin
      logic [15:0] lo, hi;
      lo = 16'h1000 + 16'(i * 256);
      hi = 16'h8000 + 16'(i * 256);
      stage(i, 2'd3, 8'h80 | 8'(i % 4), lo, hi, 16'd1);
      commit_req();
    end
    for (int i = 0; i < NCH; i++) begin
      logic [15:0] lo, hi;
      logic [15:0] pat [5];
      lo = 16'h1000 + 16'(i * 256);
      hi = 16'h8000 + 16'(i * 256);
      pat[0] = lo - 16'd1; pat[1] = lo; pat[2] = hi; pat[3] = hi + 16'd1; pat[4] = lo + 16'h0010;
      for (int p = 0; p < 5; p++) begin
        logic elo, ehi;
        wr(8'h01, 8'hFF);
        wr(8'h03, 8'hFF);
        wait_cyc(T + 1);
        feed(i, pat[p]);
        exp_data[i] = pat[p];
        elo = (i % 2 == 1) && (pat[p] < lo);
        ehi = ((i / 2) % 2 == 1) && (pat[p] > hi);
        rd16(i, w); chk("R5 result register", w, exp_data[i]);
        rd(8'h00, b); chk("R6 low status", b, elo ? 8'(1 << i) : 8'h00);
        rd(8'h02, b); chk("R7 high status", b, ehi ? 8'(1 << i) : 8'h00);
        chk("R9 irq follows status", irq, elo | ehi);
      end
    end
    for (int i = 0; i < NCH; i++) begin
      rd16(i, w); chk("R11 other slots kept their result", w, exp_data[i]);
    end

    // R8 sticky status and clear views (slot 3 has both enables)
    wr(8'h01, 8'hFF); wr(8'h03, 8'hFF);
    wait_cyc(T + 1);
    feed(3, 16'h0001);
    wait_cyc(T + 1);
    feed(3, 16'h4000);
    rd(8'h00, b); chk("R8 low bit sticky after in-range reading", b, 8'h08);
    chk("R9 irq while set", irq, 1'b1);
    wr(8'h00, 8'hFF);
    rd(8'h00, b); chk("R8 write to status view ignored", b, 8'h08);
    wr(8'h01, 8'hF7);
    rd(8'h00, b); chk("R8 clear of other bits", b, 8'h08);
    wr(8'h01, 8'h08);
    rd(8'h00, b); chk("R8 clear by writing one", b, 8'h00);
    chk("R9 irq low after clear", irq, 1'b0);
    wait_cyc(T + 1);
    feed(3, 16'hFFFF);
    wr(8'h02, 8'h00);
    rd(8'h02, b); chk("R8 high view write ignored", b, 8'h08);
    wr(8'h03, 8'h08);
    rd(8'h02, b); chk("R8 high clear", b, 8'h00);
    exp_data[3] = 16'hFFFF;

    // R10 slot committed with measurement off
    stage(2, 2'd3, 8'h03, 16'h1000, 16'h2000, 16'd1);
    commit_req();
    wait_cyc(4 * T);
    feed(2, 16'h0001);
    rd(8'h00, b); chk("R10 no status from stopped slot", b, 8'h00);
    rd16(2, w); chk("R10 result unchanged", w, exp_data[2]);

    // R3 requests ignored when disabled or without flag
    stage(2, 2'd3, 8'h83, 16'h1000, 16'h2000, 16'd1);
    wr(8'h18, 8'h00);
    wr(8'h04, 8'h01);
    wr(8'h19, 8'h80);
    rd(8'h04, b); chk("R3 flag kept when disabled", b, 8'h01);
    wait_cyc(4 * T);
    feed(2, 16'h0001);
    rd(8'h00, b); chk("R3 slot unchanged when disabled", b, 8'h00);
    wr(8'h18, 8'h80);
    wr(8'h04, 8'h00);
    wr(8'h19, 8'h80);
    wait_cyc(4 * T);
    feed(2, 16'h0001);
    rd(8'h00, b); chk("R3 slot unchanged without flag", b, 8'h00);
    wr(8'h04, 8'h01);
    wr(8'h19, 8'h80);
    rd(8'h04, b); chk("R2 flag cleared on accept", b, 8'h00);
    wait_cyc(T + 1);
    feed(2, 16'h0001);
    rd(8'h00, b); chk("R2 committed slot now monitors", b, 8'h04);
    rd16(2, w); chk("R5 committed slot stores reading", w, 16'h0001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule